// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the test port of a small programmable-logic device. A serial four-wire port (clock, mode select, data in, data out) steps a sixteen-state controller. The controller moves bits through an instruction register and through one of three data paths. The paths are a one-bit pass-through, a 32-bit identification word, and a chain of boundary cells that sit between the device pads and its core logic. There is no dedicated port reset. The controller reaches its reset state in three ways: from the power-up reset, after five clocks with mode select held high, or while the port is switched off.

Each input-only pad has one cell, which samples the pad value. Each bidirectional pad has one cell with three stages: the pad value, the output data offered by the core, and the output enable offered by the core. The two output stages also feed a pair of update latches. A mode multiplexer inside the cell chooses whether the pad is driven from the core, from the update latches, or not driven at all. Five operations are decoded: pad sampling with preload, external test, pass-through, identification, and pad release. When the port-enable input is low, the port drives nothing and the core keeps full control of the pads.

Top module: `jtag_tap_bscan`

## Requirements
- R1: While `rst_ni` is low and just after it rises, the controller is in Test-Logic-Reset, identification is the current instruction, `tdo_oe_o` is low, and each bidirectional pad takes its data and enable from the core.
- R2: Five consecutive rising TCK edges with TMS high put the controller in Test-Logic-Reset from any state, and the instruction returns to identification.
- R3: The instruction register is 4 bits wide and is shifted LSB first. It loads 4'b0001 in Capture-IR. The codes are 4'h0 external test, 4'h1 sample/preload, 4'h2 pad release, 4'h3 identification and 4'hF pass-through. Every other code acts as pass-through.
- R4: The identification path is 32 bits, shifted LSB first. It captures parameter `ID_VALUE` with bit 0 forced to 1.
- R5: The pass-through path is one stage. It captures 0, and TDI reaches TDO one shift later.
- R6: The boundary chain is read LSB first from TDO. Bits 0 to N_IN-1 hold input pads 0 and up. Bidirectional cell k then takes bits N_IN+3k (pad value), N_IN+3k+1 (core output data) and N_IN+3k+2 (core output enable). The chain captures in Capture-DR only under sample/preload or external test.
- R7: The update latches load the output-data and output-enable stages on the falling TCK edge in Update-DR, and only under sample/preload or external test. They hold through every other shift and instruction.
- R8: Under external test, the bidirectional pads are driven from the update latches. Under any other instruction except pad release, they are driven from the core.
- R9: Under pad release, every bidirectional pad enable is low and the pass-through path is selected.
- R10: TDO changes on the falling TCK edge, and `tdo_oe_o` is high exactly while the controller is in Shift-IR or Shift-DR.
- R11: While `jtag_en_i` is low, the controller is held in Test-Logic-Reset, `tdo_oe_o` stays low and the pads follow the core. When the port is enabled again, identification is the current instruction.
- R12: The core-side inputs `in_core_o` and `io_core_in_o` always follow their pads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Power-up reset, active low, asynchronous |
| jtag_en_i | input | 1 | Port enable configuration bit |
| tms_i | input | 1 | Mode select |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |
| tdo_oe_o | output | 1 | Drive enable for serial data out |
| in_pad_i | input | N_IN | Input-only pad values |
| in_core_o | output | N_IN | Input pad values to the core |
| io_pad_i | input | N_IO | Bidirectional pad values |
| io_core_in_o | output | N_IO | Bidirectional pad values to the core |
| io_core_out_i | input | N_IO | Output data from the core |
| io_core_oe_i | input | N_IO | Output enable from the core |
| io_pad_out_o | output | N_IO | Data driven to the bidirectional pads |
| io_pad_oe_o | output | N_IO | Enable for the bidirectional pads |

## Verification
The bench builds the block with three input pads, two bidirectional pads and an identification value whose bit 0 is clear. This makes the boundary chain nine bits long, so every cell position can be checked by a full scan. It also shows the forced LSB in the identification read. With two bidirectional cells, the preload, external-test and update-hold sequences can give each pad a distinct data and enable pattern. A behavioural controller model in the bench predicts the serial output enable on every clock.

// File: rtl/jtag_bs_pkg.sv
package jtag_bs_pkg;
  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE, TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PA_DR, TS_EX2_DR,
    TS_UPD_DR, TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PA_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 4'h0;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'h1;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 4'h2;
  localparam logic [IR_W-1:0] OP_IDCODE  = 4'h3;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'hF;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
    case (s)
      TS_RESET:  return tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   return tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: return tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: return tms ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  return tms ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: return tms ? TS_UPD_DR : TS_PA_DR;
      TS_PA_DR:  return tms ? TS_EX2_DR : TS_PA_DR;
      TS_EX2_DR: return tms ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: return tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: return tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: return tms ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  return tms ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: return tms ? TS_UPD_IR : TS_PA_IR;
      TS_PA_IR:  return tms ? TS_EX2_IR : TS_PA_IR;
      TS_EX2_IR: return tms ? TS_UPD_IR : TS_SH_IR;
      default:   return tms ? TS_SEL_DR : TS_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_bs_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= TS_RESET;
    else if (!en_i) state_q <= TS_RESET;
    else            state_q <= tap_next(state_q, tms_i);
  end

  assign state_o = state_q;
endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
  import jtag_bs_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] ir_o,
  output logic            so_o
);
  logic [IR_W-1:0] sh_q, ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                  sh_q <= '0;
    else if (state_i == TS_CAP_IR) sh_q <= IR_CAPTURE;
    else if (state_i == TS_SH_IR)  sh_q <= {tdi_i, sh_q[IR_W-1:1]};
  end

  // instruction register updates on the falling edge
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                   ir_q <= OP_IDCODE;
    else if (state_i == TS_RESET)  ir_q <= OP_IDCODE;
    else if (state_i == TS_UPD_IR) ir_q <= sh_q;
  end

  assign ir_o = ir_q;
  assign so_o = sh_q[0];
endmodule

// File: rtl/jtag_bsc_cells.sv
module jtag_bsc_in (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic shift_i,
  input  logic pad_i,
  input  logic si_i,
  output logic so_o
);
  logic q;
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        q <= 1'b0;
    else if (capture_i) q <= pad_i;
    else if (shift_i)   q <= si_i;
  end
  assign so_o = q;
endmodule

module jtag_bsc_io (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic extest_i,
  input  logic highz_i,
  input  logic si_i,
  input  logic pad_i,
  input  logic core_out_i,
  input  logic core_oe_i,
  output logic so_o,
  output logic pad_out_o,
  output logic pad_oe_o,
  output logic upd_out_o,
  output logic upd_oe_o
);
  logic pad_q, out_q, oe_q, upd_out_q, upd_oe_q;

  // chain order inside the cell: si -> oe -> out -> pad -> so
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pad_q <= 1'b0; out_q <= 1'b0; oe_q <= 1'b0;
    end else if (capture_i) begin
      pad_q <= pad_i; out_q <= core_out_i; oe_q <= core_oe_i;
    end else if (shift_i) begin
      oe_q <= si_i; out_q <= oe_q; pad_q <= out_q;
    end
  end

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_out_q <= 1'b0; upd_oe_q <= 1'b0;
    end else if (update_i) begin
      upd_out_q <= out_q; upd_oe_q <= oe_q;
    end
  end

  assign so_o      = pad_q;
  assign pad_out_o = extest_i ? upd_out_q : core_out_i;
  assign pad_oe_o  = highz_i ? 1'b0 : (extest_i ? upd_oe_q : core_oe_i);
  assign upd_out_o = upd_out_q;
  assign upd_oe_o  = upd_oe_q;
endmodule

// File: rtl/jtag_bsr.sv
module jtag_bsr #(
  parameter int N_IN = 4,
  parameter int N_IO = 4
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            capture_i,
  input  logic            shift_i,
  input  logic            update_i,
  input  logic            extest_i,
  input  logic            highz_i,
  input  logic            tdi_i,
  input  logic [N_IN-1:0] in_pad_i,
  input  logic [N_IO-1:0] io_pad_i,
  input  logic [N_IO-1:0] io_core_out_i,
  input  logic [N_IO-1:0] io_core_oe_i,
  output logic [N_IO-1:0] io_pad_out_o,
  output logic [N_IO-1:0] io_pad_oe_o,
  output logic [N_IO-1:0] upd_out_o,
  output logic [N_IO-1:0] upd_oe_o,
  output logic            so_o
);
  localparam int N_CELL = N_IN + N_IO;

  logic [N_CELL:0] link;
  assign link[N_CELL] = tdi_i;
  assign so_o         = link[0];

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    jtag_bsc_in u_cell (
      .tck_i(tck_i), .rst_ni(rst_ni), .capture_i(capture_i), .shift_i(shift_i),
      .pad_i(in_pad_i[i]), .si_i(link[i+1]), .so_o(link[i])
    );
  end

  for (genvar k = 0; k < N_IO; k++) begin : g_io
    jtag_bsc_io u_cell (
      .tck_i(tck_i), .rst_ni(rst_ni), .capture_i(capture_i), .shift_i(shift_i),
      .update_i(update_i), .extest_i(extest_i), .highz_i(highz_i),
      .si_i(link[N_IN+k+1]), .pad_i(io_pad_i[k]), .core_out_i(io_core_out_i[k]),
      .core_oe_i(io_core_oe_i[k]), .so_o(link[N_IN+k]),
      .pad_out_o(io_pad_out_o[k]), .pad_oe_o(io_pad_oe_o[k]),
      .upd_out_o(upd_out_o[k]), .upd_oe_o(upd_oe_o[k])
    );
  end
endmodule

// File: rtl/jtag_tap_bscan.sv
module jtag_tap_bscan
  import jtag_bs_pkg::*;
#(
  parameter int          N_IN     = 4,
  parameter int          N_IO     = 4,
  parameter logic [31:0] ID_VALUE = 32'h0B5C_E03F
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            jtag_en_i,
  input  logic            tms_i,
  input  logic            tdi_i,
  output logic            tdo_o,
  output logic            tdo_oe_o,
  input  logic [N_IN-1:0] in_pad_i,
  output logic [N_IN-1:0] in_core_o,
  input  logic [N_IO-1:0] io_pad_i,
  output logic [N_IO-1:0] io_core_in_o,
  input  logic [N_IO-1:0] io_core_out_i,
  input  logic [N_IO-1:0] io_core_oe_i,
  output logic [N_IO-1:0] io_pad_out_o,
  output logic [N_IO-1:0] io_pad_oe_o
);
  localparam logic [31:0] ID_CAPTURE = ID_VALUE | 32'd1;

  tap_state_e      state_q;
  logic [IR_W-1:0] ir_q;
  logic            ir_so, bsr_so, byp_q, dr_so;
  logic [31:0]     id_q;
  logic [N_IO-1:0] upd_out, upd_oe;
  logic            sel_bsr, sel_id, is_extest, is_highz;
  logic            cap_dr, sh_dr, sh_ir;
  logic            tdo_q, tdo_oe_q;

  jtag_tap_fsm u_fsm (
    .tck_i(tck_i), .rst_ni(rst_ni), .en_i(jtag_en_i), .tms_i(tms_i), .state_o(state_q)
  );

  jtag_tap_ir u_ir (
    .tck_i(tck_i), .rst_ni(rst_ni), .state_i(state_q), .tdi_i(tdi_i),
    .ir_o(ir_q), .so_o(ir_so)
  );

  assign is_extest = (ir_q == OP_EXTEST);
  assign is_highz  = (ir_q == OP_HIGHZ);
  assign sel_bsr   = is_extest || (ir_q == OP_SAMPLE);
  assign sel_id    = (ir_q == OP_IDCODE);
  assign cap_dr    = (state_q == TS_CAP_DR);
  assign sh_dr     = (state_q == TS_SH_DR);
  assign sh_ir     = (state_q == TS_SH_IR);

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q <= 1'b0;
      id_q  <= '0;
    end else begin
      if (cap_dr)     byp_q <= 1'b0;
      else if (sh_dr) byp_q <= tdi_i;
      if (cap_dr)     id_q <= ID_CAPTURE;
      else if (sh_dr) id_q <= {tdi_i, id_q[31:1]};
    end
  end

  jtag_bsr #(.N_IN(N_IN), .N_IO(N_IO)) u_bsr (
    .tck_i(tck_i), .rst_ni(rst_ni),
    .capture_i(cap_dr && sel_bsr), .shift_i(sh_dr && sel_bsr),
    .update_i((state_q == TS_UPD_DR) && sel_bsr),
    .extest_i(is_extest), .highz_i(is_highz), .tdi_i(tdi_i),
    .in_pad_i(in_pad_i), .io_pad_i(io_pad_i),
    .io_core_out_i(io_core_out_i), .io_core_oe_i(io_core_oe_i),
    .io_pad_out_o(io_pad_out_o), .io_pad_oe_o(io_pad_oe_o),
    .upd_out_o(upd_out), .upd_oe_o(upd_oe), .so_o(bsr_so)
  );

  assign dr_so = sel_bsr ? bsr_so : (sel_id ? id_q[0] : byp_q);

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q <= 1'b0; tdo_oe_q <= 1'b0;
    end else begin
      tdo_oe_q <= sh_ir || sh_dr;
      tdo_q    <= sh_ir ? ir_so : (sh_dr ? dr_so : 1'b0);
    end
  end

  assign tdo_o        = tdo_q;
  assign tdo_oe_o     = tdo_oe_q;
  assign in_core_o    = in_pad_i;
  assign io_core_in_o = io_pad_i;
endmodule

// File: rtl/jtag_tap_bscan_chk.sv
module jtag_tap_bscan_chk
  import jtag_bs_pkg::*;
#(
  parameter int N_IO = 4
) (
  input logic            tck_i,
  input logic            rst_ni,
  input logic            jtag_en_i,
  input logic            tms_i,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir,
  input logic            tdo_oe_o,
  input logic [N_IO-1:0] io_pad_out_o,
  input logic [N_IO-1:0] io_pad_oe_o,
  input logic [N_IO-1:0] upd_out,
  input logic [N_IO-1:0] upd_oe
);
  a_r2_tms_five_high: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (tms_i && $past(tms_i) && $past(tms_i, 2) && $past(tms_i, 3) && $past(tms_i, 4))
      |=> state == TS_RESET);

  a_r7_update_hold: assert property (@(negedge tck_i) disable iff (!rst_ni)
    (state != TS_UPD_DR) |=> ($stable(upd_out) && $stable(upd_oe)));

  a_r8_extest_drive: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ir == OP_EXTEST) |-> (io_pad_out_o == upd_out && io_pad_oe_o == upd_oe));

  a_r9_highz_release: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ir == OP_HIGHZ) |-> io_pad_oe_o == '0);

  a_r10_tdo_enable: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_oe_o == (state == TS_SH_DR || state == TS_SH_IR));

  a_r11_port_off: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !jtag_en_i |=> state == TS_RESET);
endmodule

bind jtag_tap_bscan jtag_tap_bscan_chk #(.N_IO(N_IO)) u_chk (
  .tck_i(tck_i), .rst_ni(rst_ni), .jtag_en_i(jtag_en_i), .tms_i(tms_i),
  .state(state_q), .ir(ir_q), .tdo_oe_o(tdo_oe_o),
  .io_pad_out_o(io_pad_out_o), .io_pad_oe_o(io_pad_oe_o),
  .upd_out(upd_out), .upd_oe(upd_oe)
);

// File: tb/jtag_tap_bscan_tb.sv
module jtag_tap_bscan_tb;
  localparam int          NI = 3;
  localparam int          NO = 2;
  localparam int          BL = NI + 3*NO;
  localparam logic [31:0] ID = 32'h1A5C_3E26;

  localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_SHD = 4, S_E1D = 5,
                 S_PD = 6, S_E2D = 7, S_UD = 8, S_SIR = 9, S_CIR = 10, S_SHI = 11,
                 S_E1I = 12, S_PI = 13, S_E2I = 14, S_UI = 15;

  logic tck_i = 1'b0, rst_ni = 1'b0, jtag_en_i = 1'b1, tms_i = 1'b1, tdi_i = 1'b0;
  logic tdo_o, tdo_oe_o;
  logic [NI-1:0] in_pad_i = 3'b101, in_core_o;
  logic [NO-1:0] io_pad_i = 2'b10, io_core_in_o;
  logic [NO-1:0] io_core_out_i = 2'b01, io_core_oe_i = 2'b11;
  logic [NO-1:0] io_pad_out_o, io_pad_oe_o;

  int total = 0, bad = 0, ms = S_TLR;
  logic smp_tdo;
  logic [31:0] d, exp_v;
  logic [3:0]  c;

  jtag_tap_bscan #(.N_IN(NI), .N_IO(NO), .ID_VALUE(ID)) u_dut (.*);

  always #10 tck_i = ~tck_i;

  function automatic int nxt(input int s, input logic t);
    case (s)
      S_TLR: return t ? S_TLR : S_RTI;
      S_RTI: return t ? S_SDR : S_RTI;
      S_SDR: return t ? S_SIR : S_CDR;
      S_CDR, S_SHD: return t ? S_E1D : S_SHD;
      S_E1D: return t ? S_UD : S_PD;
      S_PD:  return t ? S_E2D : S_PD;
      S_E2D: return t ? S_UD : S_SHD;
      S_SIR: return t ? S_TLR : S_CIR;
      S_CIR, S_SHI: return t ? S_E1I : S_SHI;
      S_E1I: return t ? S_UI : S_PI;
      S_PI:  return t ? S_E2I : S_PI;
      S_E2I: return t ? S_UI : S_SHI;
      default: return t ? S_SDR : S_RTI;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  // one TCK: drive after falling edge, sample before rising edge
  task automatic tick(input logic tms, input logic tdi);
    logic e;
    tms_i = tms; tdi_i = tdi;
    #8 smp_tdo = tdo_o;
    @(posedge tck_i);
    ms = !jtag_en_i ? S_TLR : nxt(ms, tms);
    @(negedge tck_i); #1;
    e = (ms == S_SHD || ms == S_SHI);
    chk(tdo_oe_o === e, "R10", {31'd0, tdo_oe_o}, {31'd0, e});
  endtask

  task automatic scan_ir(input logic [3:0] op, output logic [3:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, op[i]); cap[i] = smp_tdo;
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scan_dr(input logic [31:0] din, input int n, input bit upd, output logic [31:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      tick(i == n-1, din[i]); dout[i] = smp_tdo;
    end
    if (upd) begin tick(1, 0); tick(0, 0); end
  endtask

  function automatic logic [31:0] bsr_exp();
    logic [31:0] v = '0;
    for (int i = 0; i < NI; i++) v[i] = in_pad_i[i];
    for (int k = 0; k < NO; k++) begin
      v[NI+3*k]   = io_pad_i[k];
      v[NI+3*k+1] = io_core_out_i[k];
      v[NI+3*k+2] = io_core_oe_i[k];
    end
    return v;
  endfunction

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge tck_i);
    total++; bad++;
    $display("FAIL R10 watchdog act=hung exp=finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge tck_i);
    @(negedge tck_i); #1 rst_ni = 1'b1;
    // R1 reset state
    chk(tdo_oe_o === 1'b0, "R1", {31'd0, tdo_oe_o}, 0);
    chk(io_pad_oe_o === io_core_oe_i && io_pad_out_o === io_core_out_i, "R1",
        {io_pad_oe_o, io_pad_out_o}, {io_core_oe_i, io_core_out_i});
    chk(in_core_o === in_pad_i && io_core_in_o === io_pad_i, "R12",
        {in_core_o, io_core_in_o}, {in_pad_i, io_pad_i});
    tick(0, 0);
    // R4 default instruction reads identification
    scan_dr(32'h0, 32, 1, d);
    chk(d === (ID | 32'd1), "R4", d, ID | 32'd1);
    // R3 capture pattern, R5 pass-through
    scan_ir(4'hF, c);
    chk(c === 4'b0001, "R3", {28'd0, c}, 32'd1);
    scan_dr(32'hB3, 8, 1, d);
    chk(d[7:0] === 8'h66, "R5", d, 32'h66);
    // R3 unknown code acts as pass-through
    scan_ir(4'h9, c);
    chk(c === 4'b0001, "R3", {28'd0, c}, 32'd1);
    scan_dr(32'h13, 5, 1, d);
    chk(d[4:0] === 5'b00110, "R3", d, 32'h6);
    // R6 sample and preload
    scan_ir(4'h1, c);
    exp_v = bsr_exp();
    scan_dr(32'h130, BL, 1, d);
    chk(d[BL-1:0] === exp_v[BL-1:0], "R6", d, exp_v);
    chk(io_pad_out_o === io_core_out_i && io_pad_oe_o === io_core_oe_i, "R8",
        {io_pad_oe_o, io_pad_out_o}, {io_core_oe_i, io_core_out_i});
    // R8 external test drives preloaded values
    scan_ir(4'h0, c);
    chk(io_pad_out_o === 2'b01 && io_pad_oe_o === 2'b11, "R8",
        {io_pad_oe_o, io_pad_out_o}, {2'b11, 2'b01});
    io_core_out_i = 2'b10; in_pad_i = 3'b010; io_pad_i = 2'b01;
    chk(in_core_o === in_pad_i && io_core_in_o === io_pad_i, "R12",
        {in_core_o, io_core_in_o}, {in_pad_i, io_pad_i});
    exp_v = bsr_exp();
    scan_dr(32'h180, BL, 0, d);
    chk(d[BL-1:0] === exp_v[BL-1:0], "R6", d, exp_v);
    chk(io_pad_out_o === 2'b01 && io_pad_oe_o === 2'b11, "R7",
        {io_pad_oe_o, io_pad_out_o}, {2'b11, 2'b01});
    tick(1, 0);
    chk(io_pad_out_o === 2'b10 && io_pad_oe_o === 2'b10, "R7",
        {io_pad_oe_o, io_pad_out_o}, {2'b10, 2'b10});
    tick(0, 0);
    // R7 latches hold across another instruction
    scan_ir(4'h3, c);
    chk(io_pad_out_o === io_core_out_i, "R8", {30'd0, io_pad_out_o}, {30'd0, io_core_out_i});
    scan_dr(32'hFFFF_FFFF, 32, 1, d);
    chk(d === (ID | 32'd1), "R4", d, ID | 32'd1);
    scan_ir(4'h0, c);
    chk(io_pad_out_o === 2'b10 && io_pad_oe_o === 2'b10, "R7",
        {io_pad_oe_o, io_pad_out_o}, {2'b10, 2'b10});
    // R9 pad release
    scan_ir(4'h2, c);
    chk(io_pad_oe_o === 2'b00, "R9", {30'd0, io_pad_oe_o}, 0);
    scan_dr(32'h6, 4, 1, d);
    chk(d[3:0] === 4'b1100, "R9", d, 32'hC);
    // R2 five TMS highs from inside a shift
    tick(1, 0); tick(0, 0); tick(0, 0);
    repeat (5) tick(1, 0);
    chk(ms == S_TLR && io_pad_oe_o === io_core_oe_i, "R2",
        {30'd0, io_pad_oe_o}, {30'd0, io_core_oe_i});
    tick(0, 0);
    scan_dr(32'h0, 32, 1, d);
    chk(d === (ID | 32'd1), "R2", d, ID | 32'd1);
    // R11 port disabled
    scan_ir(4'h0, c);
    chk(io_pad_out_o === 2'b10 && io_pad_oe_o === 2'b10, "R8",
        {io_pad_oe_o, io_pad_out_o}, {2'b10, 2'b10});
    jtag_en_i = 1'b0;
    tick(1, 0); tick(0, 0); tick(0, 0); tick(0, 0);
    chk(tdo_oe_o === 1'b0, "R11", {31'd0, tdo_oe_o}, 0);
    chk(io_pad_out_o === io_core_out_i && io_pad_oe_o === io_core_oe_i, "R11",
        {io_pad_oe_o, io_pad_out_o}, {io_core_oe_i, io_core_out_i});
    jtag_en_i = 1'b1;
    tick(0, 0);
    scan_dr(32'h0, 32, 1, d);
    chk(d === (ID | 32'd1), "R11", d, ID | 32'd1);
    summary();
  end
endmodule